// File: doc/BRIEF.md
# Read-Sequence Command Unlock Detector

This block sits beside a parallel memory interface and watches every access the interface performs. Each access arrives as a one-cycle strobe that has already been qualified by chip enable, together with a read/write flag and a 13-bit address. A protected command is unlocked only when reads hit a fixed series of addresses in strict order. The series has five common prefix addresses followed by one final address. The final address chooses between two commands: a STORE request, which copies the array into non-volatile cells, and a RECALL request, which goes the other way.

Any write, and any read that does not match the expected address, throws the attempt away. A read of the first prefix address is the one exception: it starts a new attempt at once. The output-enable level is not an input to the block, so it cannot affect acceptance. While the downstream store/recall engine reports that it is busy, the block ignores accesses completely. The requests are registered, single-cycle pulses that the engine consumes directly. A progress count shows how many steps have been accepted so far.

Top module: `cmdUnlockDetector`

## Requirements
- R1: A synchronous active-low reset returns progress to 0 and holds both request outputs low, including when the reset arrives in the middle of a sequence.
- R2: With busy low, reads at 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0, taken in that order, move the progress count from 0 to 1, 2, 3, 4 and 5. Each new value appears on the clock edge that samples the access. Cycles with no access strobe leave the count unchanged.
- R3: At progress 5, a read of 0x0F0F drives storeReq high for exactly the one cycle after the access edge, and progress returns to 0.
- R4: At progress 5, a read of 0x0F0E drives recallReq high for exactly the one cycle after the access edge, and progress returns to 0.
- R5: A write access with busy low sets progress to 0 and issues no request, whatever the address and the current progress. A write to 0x0000 does not start an attempt.
- R6: With busy low, a read whose address is not the one expected at the current progress aborts the attempt without a request. Progress becomes 1 if that address is 0x0000 and 0 otherwise.
- R7: While busy is high, accesses are ignored: progress is unchanged and no request follows.
- R8: storeReq and recallReq are never high together. Each request is preceded, on the previous cycle, by progress 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| accessValid | input | 1 | One-cycle strobe marking a chip-enable-qualified access |
| isWrite | input | 1 | 1 marks the access as a write, 0 as a read |
| addr | input | 13 | Address of the access |
| busy | input | 1 | High while the store/recall engine is working; accesses are then ignored |
| storeReq | output | 1 | Single-cycle STORE request pulse |
| recallReq | output | 1 | Single-cycle RECALL request pulse |
| stepCount | output | 3 | Number of sequence steps accepted so far (0 to 5) |

## Verification
The embedded properties check several things on every cycle: progress never goes past 5, the two requests are mutually exclusive, and each request comes from progress 5 and leaves progress at 0. They also check that an accepted write always lands at 0 and that a busy cycle changes nothing. Only the bench's scenarios can show that the address order is correct and that each exact final address selects its command. The same holds for the restart-on-0x0000 rule after an abort, which the bench covers at every progress level, with an exhaustive sweep of all 8192 addresses at the final step.

// File: rtl/unlock_pkg.sv
package unlockPkg;

  // Strobes sent from the sequence control to the datapath registers.
  typedef struct packed {
    logic advance;     // step count + 1
    logic clear;       // step count -> 0
    logic restart;     // step count -> 1 (abort landed on first address)
    logic fireStore;   // pulse store request next cycle
    logic fireRecall;  // pulse recall request next cycle
  } seqStrobes_t;

endpackage

// File: rtl/unlock_datapath.sv
module unlockDatapath
  import unlockPkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int PREFIX_LEN = 5,
  parameter int STEP_W     = 3,
  parameter logic [PREFIX_LEN*ADDR_W-1:0] PREFIX_ADDRS =
    {13'h10F0, 13'h1FFF, 13'h0AAA, 13'h1555, 13'h0000},
  parameter logic [ADDR_W-1:0] STORE_ADDR  = 13'h0F0F,
  parameter logic [ADDR_W-1:0] RECALL_ADDR = 13'h0F0E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  seqStrobes_t       strb,
  output logic [STEP_W-1:0] stepCnt,
  output logic              storeReq,
  output logic              recallReq,
  output logic              prefixMatch,
  output logic              startMatch,
  output logic              storeMatch,
  output logic              recallMatch
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PREFIX_LEN);

  logic [PREFIX_LEN-1:0] stepHit;

  // One comparator per prefix position.
  for (genvar i = 0; i < PREFIX_LEN; i++) begin : gHit
    assign stepHit[i] = (addr == PREFIX_ADDRS[i*ADDR_W +: ADDR_W]);
  end

  always_comb begin
    prefixMatch = 1'b0;
    for (int i = 0; i < PREFIX_LEN; i++) begin
      if (stepCnt == STEP_W'(i)) prefixMatch = stepHit[i];
    end
  end

  assign startMatch  = stepHit[0];
  assign storeMatch  = (addr == STORE_ADDR);
  assign recallMatch = (addr == RECALL_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepCnt   <= '0;
      storeReq  <= 1'b0;
      recallReq <= 1'b0;
    end else begin
      storeReq  <= strb.fireStore;
      recallReq <= strb.fireRecall;
      if (strb.clear)        stepCnt <= '0;
      else if (strb.restart) stepCnt <= STEP_W'(1);
      else if (strb.advance) stepCnt <= stepCnt + STEP_W'(1);
    end
  end

  // R2: progress never passes the final step
  a_r2_step_bound: assert property (@(posedge clk) disable iff (!rstN)
    stepCnt <= LAST_STEP);

  // R8: requests are exclusive
  a_r8_req_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({storeReq, recallReq}));

  // R3: a store request follows the final step and leaves progress idle
  a_r3_store_from_last: assert property (@(posedge clk) disable iff (!rstN)
    $rose(storeReq) |-> ($past(stepCnt) == LAST_STEP) && (stepCnt == '0));

  // R4: a recall request follows the final step and leaves progress idle
  a_r4_recall_from_last: assert property (@(posedge clk) disable iff (!rstN)
    $rose(recallReq) |-> ($past(stepCnt) == LAST_STEP) && (stepCnt == '0));

  // R3: store request is a single-cycle pulse
  a_r3_store_single: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |=> !storeReq);

  // R4: recall request is a single-cycle pulse
  a_r4_recall_single: assert property (@(posedge clk) disable iff (!rstN)
    recallReq |=> !recallReq);

endmodule

// File: rtl/unlock_control.sv
module unlockControl
  import unlockPkg::*;
#(
  parameter int PREFIX_LEN = 5,
  parameter int STEP_W     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accessValid,
  input  logic              isWrite,
  input  logic              busy,
  input  logic [STEP_W-1:0] stepCnt,
  input  logic              prefixMatch,
  input  logic              startMatch,
  input  logic              storeMatch,
  input  logic              recallMatch,
  output seqStrobes_t       strb
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PREFIX_LEN);

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_WRITE,
    ACC_READ
  } accKind_t;

  accKind_t accKind;
  logic     atFinal;

  always_comb begin
    if (!accessValid || busy) accKind = ACC_NONE;
    else if (isWrite)         accKind = ACC_WRITE;
    else                      accKind = ACC_READ;
  end

  assign atFinal = (stepCnt == LAST_STEP);

  always_comb begin
    strb = '0;
    unique case (accKind)
      ACC_NONE: ;
      ACC_WRITE: strb.clear = 1'b1;
      ACC_READ: begin
        if (atFinal) begin
          if (storeMatch) begin
            strb.fireStore = 1'b1;
            strb.clear     = 1'b1;
          end else if (recallMatch) begin
            strb.fireRecall = 1'b1;
            strb.clear      = 1'b1;
          end else if (startMatch) begin
            strb.restart = 1'b1;
          end else begin
            strb.clear = 1'b1;
          end
        end else if (prefixMatch) begin
          strb.advance = 1'b1;
        end else if (startMatch) begin
          strb.restart = 1'b1;
        end else begin
          strb.clear = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // R5: an accepted write always leaves progress at zero
  a_r5_write_aborts: assert property (@(posedge clk) disable iff (!rstN)
    (accessValid && isWrite && !busy) |=> (stepCnt == '0));

  // R6: a failed read lands on step 0 or 1 only
  a_r6_abort_landing: assert property (@(posedge clk) disable iff (!rstN)
    (accessValid && !isWrite && !busy && !atFinal && !prefixMatch)
      |=> (stepCnt <= STEP_W'(1)));

endmodule

// File: rtl/cmdUnlockDetector.sv
module cmdUnlockDetector
  import unlockPkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int PREFIX_LEN = 5,
  parameter logic [PREFIX_LEN*ADDR_W-1:0] PREFIX_ADDRS =
    {13'h10F0, 13'h1FFF, 13'h0AAA, 13'h1555, 13'h0000},
  parameter logic [ADDR_W-1:0] STORE_ADDR  = 13'h0F0F,
  parameter logic [ADDR_W-1:0] RECALL_ADDR = 13'h0F0E,
  localparam int STEP_W = $clog2(PREFIX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accessValid,
  input  logic              isWrite,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  output logic              storeReq,
  output logic              recallReq,
  output logic [STEP_W-1:0] stepCount
);

  seqStrobes_t strb;
  logic        prefixMatch;
  logic        startMatch;
  logic        storeMatch;
  logic        recallMatch;

  unlockControl #(
    .PREFIX_LEN (PREFIX_LEN),
    .STEP_W     (STEP_W)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .accessValid (accessValid),
    .isWrite     (isWrite),
    .busy        (busy),
    .stepCnt     (stepCount),
    .prefixMatch (prefixMatch),
    .startMatch  (startMatch),
    .storeMatch  (storeMatch),
    .recallMatch (recallMatch),
    .strb        (strb)
  );

  unlockDatapath #(
    .ADDR_W       (ADDR_W),
    .PREFIX_LEN   (PREFIX_LEN),
    .STEP_W       (STEP_W),
    .PREFIX_ADDRS (PREFIX_ADDRS),
    .STORE_ADDR   (STORE_ADDR),
    .RECALL_ADDR  (RECALL_ADDR)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .addr        (addr),
    .strb        (strb),
    .stepCnt     (stepCount),
    .storeReq    (storeReq),
    .recallReq   (recallReq),
    .prefixMatch (prefixMatch),
    .startMatch  (startMatch),
    .storeMatch  (storeMatch),
    .recallMatch (recallMatch)
  );

  // R7: a busy cycle changes nothing and issues nothing
  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(stepCount) && !storeReq && !recallReq);

  // R2: idle cycles keep progress
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !accessValid |=> $stable(stepCount));

endmodule

// File: tb/cmdUnlockDetector_test.sv
module cmdUnlockDetector_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        accessValid;
  logic        isWrite;
  logic [12:0] addr;
  logic        busy;
  logic        storeReq;
  logic        recallReq;
  logic [2:0]  stepCount;

  int total = 0;
  int bad   = 0;
  int modelStep = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 8 ns period

  cmdUnlockDetector uut (
    .clk         (clk),
    .rstN        (rstN),
    .accessValid (accessValid),
    .isWrite     (isWrite),
    .addr        (addr),
    .busy        (busy),
    .storeReq    (storeReq),
    .recallReq   (recallReq),
    .stepCount   (stepCount)
  );

  function automatic logic [12:0] pfx(int i);
    case (i)
      0:       return 13'h0000;
      1:       return 13'h1555;
      2:       return 13'h0AAA;
      3:       return 13'h1FFF;
      default: return 13'h10F0;
    endcase
  endfunction

  task automatic checkEq(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll(string req, int expStep, int expSt, int expRc);
    checkEq(req, "stepCount", int'(stepCount), expStep);
    checkEq(req, "storeReq", int'(storeReq), expSt);
    checkEq(req, "recallReq", int'(recallReq), expRc);
  endtask

  // One access, called at a falling edge; checks outputs at the next one.
  task automatic access(bit wr, logic [12:0] a, bit bsy, string req);
    int nxt = modelStep;
    int eSt = 0;
    int eRc = 0;
    if (!bsy) begin
      if (wr) nxt = 0;                                 // R5
      else if (modelStep == 5) begin
        if (a == 13'h0F0F)      begin eSt = 1; nxt = 0; end  // R3
        else if (a == 13'h0F0E) begin eRc = 1; nxt = 0; end  // R4
        else nxt = (a == 13'h0000) ? 1 : 0;            // R6
      end else if (a == pfx(modelStep)) nxt = modelStep + 1;  // R2
      else nxt = (a == 13'h0000) ? 1 : 0;              // R6
    end
    accessValid = 1'b1;
    isWrite     = wr;
    addr        = a;
    busy        = bsy;
    @(negedge clk);
    accessValid = 1'b0;
    busy        = 1'b0;
    checkAll(req, nxt, eSt, eRc);
    modelStep = nxt;
  endtask

  task automatic clearSeq();
    access(1'b1, 13'h0000, 1'b0, "R5");
  endtask

  task automatic primeTo(int k);
    clearSeq();
    for (int i = 0; i < k; i++) access(1'b0, pfx(i), 1'b0, "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; accessValid = 1'b0; isWrite = 1'b0; addr = '0; busy = 1'b0;
    repeat (3) @(negedge clk);
    checkAll("R1", 0, 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1", 0, 0, 0);

    // R2: full prefix, with idle gaps that must hold progress
    for (int i = 0; i < 5; i++) begin
      access(1'b0, pfx(i), 1'b0, "R2");
      @(negedge clk);
      checkAll("R2", modelStep, 0, 0);
    end
    access(1'b0, 13'h0F0F, 1'b0, "R3");
    @(negedge clk);
    checkAll("R3", 0, 0, 0);          // pulse is one cycle only
    primeTo(5);
    access(1'b0, 13'h0F0E, 1'b0, "R4");
    @(negedge clk);
    checkAll("R4", 0, 0, 0);

    // R8: back-to-back final address without a new prefix issues nothing
    access(1'b0, 13'h0F0F, 1'b0, "R8");
    access(1'b0, 13'h0F0E, 1'b0, "R8");

    // R1: reset in the middle of a sequence
    primeTo(3);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    checkAll("R1", 0, 0, 0);
    modelStep = 0;

    // R5: writes at every progress level, including to matching addresses
    for (int k = 0; k <= 5; k++) begin
      primeTo(k);
      access(1'b1, (k < 5) ? pfx(k) : 13'h0F0F, 1'b0, "R5");
      primeTo(k);
      access(1'b1, 13'h0000, 1'b0, "R5");
    end

    // R7: busy accesses are ignored, then the sequence continues
    for (int k = 0; k <= 5; k++) begin
      primeTo(k);
      access(1'b0, (k < 5) ? pfx(k) : 13'h0F0F, 1'b1, "R7");
      access(1'b1, 13'h1234, 1'b1, "R7");
      access(1'b0, (k < 5) ? pfx(k) : 13'h0F0E, 1'b0, "R7");
    end

    // R6: stepped address sweep at each prefix level
    for (int k = 0; k < 5; k++) begin
      for (int a = 0; a < 8192; a += 41) begin
        primeTo(k);
        access(1'b0, 13'(a), 1'b0, "R6");
      end
      for (int j = 0; j < 5; j++) begin
        primeTo(k);
        access(1'b0, pfx(j), 1'b0, "R6");
      end
    end

    // R3/R4/R6: exhaustive sweep of the final step
    for (int a = 0; a < 8192; a++) begin
      primeTo(5);
      if (a == 13'h0F0F)      access(1'b0, 13'(a), 1'b0, "R3");
      else if (a == 13'h0F0E) access(1'b0, 13'(a), 1'b0, "R4");
      else                    access(1'b0, 13'(a), 1'b0, "R6");
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule